// File: doc/BRIEF.md
# Mixed-Decay Current Chopper Controller

This block sequences the four gate enables of one H-bridge for a brushed DC motor. It is regulated by constant-current chopping and runs from the chopper oscillator clock. A free-running period counter splits time into fixed chopping periods. Each period starts by charging the winding from the supply. When the synchronised current-trip comparator fires, the bridge leaves charge for fast decay, which returns energy to the supply. If the trip came early enough, the bridge moves to slow decay, with both low sides on, at a fixed point in the period.

Diode recovery and switching spikes would otherwise trip the comparator falsely. To prevent this, a digital blanking timer masks the comparator for a selectable 4 or 6 clocks. The timer restarts at the start of every period and whenever the direction inputs change. A change of direction also restarts the period itself. The two direction bits select forward, reverse, stop (all switches off) or short brake.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: While driving (forward or reverse), a period lasts 16 clocks, counted 0 to 15. The first count of every period is charge.
- R2: The trip input is ignored for the first 4 counts of a period when `blank_long` is 0, and for the first 6 counts when it is 1. With trip held, decay therefore begins no earlier than count 5 or count 7 respectively.
- R3: `trip_async` passes through two flops. If it is raised during count c-2, the trip is taken at count max(c, blank length), and decay begins at the next count. A trip taken at count 15 causes no decay.
- R4: If decay begins before count 6, fast decay lasts until count 5 and slow decay runs from count 6 to 15.
- R5: If decay begins at count 6 or later, fast decay lasts to the end of the period.
- R6: Gates are read as {U1,L1,U2,L2}. Direction {dir_a,dir_b}=10 is forward: charge is 1001, fast decay is 0110 and slow decay is 0101. Direction 01 is reverse: charge is 0110, fast decay is 1001 and slow decay is 0101.
- R7: A change of the direction inputs restarts the period at count 0 in charge and restarts the blanking window.
- R8: Direction 00 (stop) drives all gates low and holds the period counter at zero, whatever the trip input does. Direction 11 (brake) drives 0101.
- R9: A new period charges even if the trip input is still asserted.
- R10: The high-side and low-side enables of the same half-bridge are never both high.
- R11: While reset is low, all gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chopper oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction bit A (10 = forward) |
| dir_b | input | 1 | Direction bit B (01 = reverse) |
| blank_long | input | 1 | Blanking select: 0 = 4 clocks, 1 = 6 clocks |
| trip_async | input | 1 | Current-trip comparator, asynchronous |
| gate_hi_a | output | 1 | High-side enable, half-bridge A (U1) |
| gate_lo_a | output | 1 | Low-side enable, half-bridge A (L1) |
| gate_hi_b | output | 1 | High-side enable, half-bridge B (U2) |
| gate_lo_b | output | 1 | Low-side enable, half-bridge B (L2) |

## Verification
The bound checker watches the following on every cycle:
- no shoot-through;
- idle gates and the held counter in stop;
- counter stepping;
- charge at count zero;
- slow decay never before the mixed-decay point;
- decay entered only after blanking with the trip seen;
- restart after a direction change.

The bench scenarios show the rest. These are the exact count at which decay begins for each blank setting and trip timing, the fast-only period for late trips, and the gate codes per direction. They also cover re-charge with the trip still held, and the effect of a direction change in mid-period.

// File: rtl/chop_pkg.sv
package chop_pkg;

   // Drive selection, encoded as {dir_a, dir_b}
   typedef enum logic [1:0] {
      DRV_STOP  = 2'b00,
      DRV_REV   = 2'b01,
      DRV_FWD   = 2'b10,
      DRV_BRAKE = 2'b11
   } drive_e;

   typedef enum logic [1:0] {
      PH_CHARGE = 2'd0,
      PH_FAST   = 2'd1,
      PH_SLOW   = 2'd2
   } phase_e;

   typedef struct packed {
      logic hi_a;
      logic lo_a;
      logic hi_b;
      logic lo_b;
   } gates_t;

   function automatic logic drive_active(drive_e m);
      return (m == DRV_FWD) || (m == DRV_REV);
   endfunction

endpackage

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] sh;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sh[STAGES-1];

endmodule

// File: rtl/chop_period_timer.sv
module chop_period_timer
   import chop_pkg::*;
#(
   parameter int PERIOD = 16,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  drive_e           mode_in,
   output drive_e           mode_q,
   output logic [CNT_W-1:0] cnt,
   output logic             active_in,
   output logic             restart
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic changed;
   logic wrap;

   always_comb begin
      active_in = drive_active(mode_in);
      changed   = (mode_in != mode_q);
      wrap      = (cnt == LAST);
      restart   = active_in && (changed || wrap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= DRV_STOP;
         cnt    <= '0;
      end else begin
         mode_q <= mode_in;
         if (!active_in || restart) cnt <= '0;
         else                       cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
   parameter int BLANK_SHORT = 4,
   parameter int BLANK_LONG  = 6,
   localparam int BLK_W = $clog2(BLANK_LONG + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic blank_long,
   output logic blank_busy
);

   localparam logic [BLK_W-1:0] LEN_S = BLK_W'(BLANK_SHORT);
   localparam logic [BLK_W-1:0] LEN_L = BLK_W'(BLANK_LONG);

   logic [BLK_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left <= '0;
      else if (restart)       left <= blank_long ? LEN_L : LEN_S;
      else if (left != '0)    left <= left - BLK_W'(1);
   end

   assign blank_busy = (left != '0);

endmodule

// File: rtl/chop_decay_fsm.sv
module chop_decay_fsm
   import chop_pkg::*;
#(
   parameter int PERIOD    = 16,
   parameter int MIX_POINT = 6,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_in,
   input  logic             restart,
   input  logic [CNT_W-1:0] cnt,
   input  logic             blank_busy,
   input  logic             trip_s,
   output phase_e           phase
);

   localparam logic [CNT_W-1:0] MIX_PRE = CNT_W'(MIX_POINT - 1);

   phase_e phase_nx;

   always_comb begin
      phase_nx = phase;
      if (!active_in || restart) begin
         phase_nx = PH_CHARGE;
      end else begin
         case (phase)
            PH_CHARGE: if (trip_s && !blank_busy) phase_nx = PH_FAST;
            PH_FAST:   if (cnt == MIX_PRE)        phase_nx = PH_SLOW;
            PH_SLOW:   phase_nx = PH_SLOW;
            default:   phase_nx = PH_CHARGE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_CHARGE;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
   import chop_pkg::*;
(
   input  drive_e mode,
   input  phase_e phase,
   output gates_t gates
);

   always_comb begin
      gates = '0;
      case (mode)
         DRV_FWD: begin
            case (phase)
               PH_CHARGE: begin gates.hi_a = 1'b1; gates.lo_b = 1'b1; end
               PH_FAST:   begin gates.hi_b = 1'b1; gates.lo_a = 1'b1; end
               PH_SLOW:   begin gates.lo_a = 1'b1; gates.lo_b = 1'b1; end
               default:   gates = '0;
            endcase
         end
         DRV_REV: begin
            case (phase)
               PH_CHARGE: begin gates.hi_b = 1'b1; gates.lo_a = 1'b1; end
               PH_FAST:   begin gates.hi_a = 1'b1; gates.lo_b = 1'b1; end
               PH_SLOW:   begin gates.lo_a = 1'b1; gates.lo_b = 1'b1; end
               default:   gates = '0;
            endcase
         end
         DRV_BRAKE: begin gates.lo_a = 1'b1; gates.lo_b = 1'b1; end
         default:   gates = '0;
      endcase
   end

endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
   import chop_pkg::*;
#(
   parameter int PERIOD      = 16,
   parameter int MIX_POINT   = 6,
   parameter int BLANK_SHORT = 4,
   parameter int BLANK_LONG  = 6,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_a,
   input  logic dir_b,
   input  logic blank_long,
   input  logic trip_async,
   output logic gate_hi_a,
   output logic gate_lo_a,
   output logic gate_hi_b,
   output logic gate_lo_b
);

   initial begin
      assert (PERIOD >= 2) else $error("PERIOD must be at least 2");
      assert (MIX_POINT > 0 && MIX_POINT < PERIOD) else $error("MIX_POINT out of range");
      assert (BLANK_SHORT >= 1 && BLANK_LONG >= BLANK_SHORT) else $error("blank lengths invalid");
      assert (BLANK_LONG < PERIOD) else $error("BLANK_LONG must be shorter than PERIOD");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   drive_e           mode_in;
   drive_e           mode_q;
   logic [CNT_W-1:0] cnt;
   logic             active_in;
   logic             restart;
   logic             blank_busy;
   logic             trip_s;
   phase_e           phase;
   gates_t           gates;

   assign mode_in = drive_e'({dir_a, dir_b});

   chop_trip_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(trip_async), .q(trip_s)
   );

   chop_period_timer #(.PERIOD(PERIOD)) i_period (
      .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .mode_q(mode_q),
      .cnt(cnt), .active_in(active_in), .restart(restart)
   );

   chop_blank_timer #(.BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)) i_blank (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .blank_long(blank_long), .blank_busy(blank_busy)
   );

   chop_decay_fsm #(.PERIOD(PERIOD), .MIX_POINT(MIX_POINT)) i_decay (
      .clk(clk), .rst_n(rst_n), .active_in(active_in), .restart(restart),
      .cnt(cnt), .blank_busy(blank_busy), .trip_s(trip_s), .phase(phase)
   );

   chop_gate_map i_map (
      .mode(mode_q), .phase(phase), .gates(gates)
   );

   assign gate_hi_a = gates.hi_a;
   assign gate_lo_a = gates.lo_a;
   assign gate_hi_b = gates.hi_b;
   assign gate_lo_b = gates.lo_b;

endmodule

// File: rtl/chop_bridge_ctrl_chk.sv
module chop_bridge_ctrl_chk
   import chop_pkg::*;
#(
   parameter int PERIOD    = 16,
   parameter int MIX_POINT = 6,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input logic             clk,
   input logic             rst_n,
   input drive_e           mode_q,
   input logic [CNT_W-1:0] cnt,
   input phase_e           phase,
   input logic             blank_busy,
   input logic             trip_s,
   input logic             gate_hi_a,
   input logic             gate_lo_a,
   input logic             gate_hi_b,
   input logic             gate_lo_b
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] MIX  = CNT_W'(MIX_POINT);

   // R10
   a_r10_no_shoot_a: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_a && gate_lo_a));
   a_r10_no_shoot_b: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_b && gate_lo_b));

   // R8
   a_r8_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == DRV_STOP) |-> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));
   a_r8_idle_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_active(mode_q) |-> (cnt == '0));

   // R1
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_active(mode_q) && ($past(mode_q) == mode_q) && ($past(cnt) != LAST))
      |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));
   a_r1_start_charge: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_active(mode_q) && cnt == '0) |-> (phase == PH_CHARGE));

   // R2
   a_r2_decay_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FAST && $past(phase) == PH_CHARGE && $past(mode_q) == mode_q)
      |-> $past(!blank_busy && trip_s));

   // R4
   a_r4_slow_late: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SLOW) |-> (cnt >= MIX));
   a_r4_slow_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SLOW && $past(phase) == PH_FAST) |-> (cnt == MIX));

   // R7
   a_r7_change_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_active(mode_q) && $past(mode_q) != mode_q) |-> (cnt == '0 && blank_busy));

endmodule

bind chop_bridge_ctrl chop_bridge_ctrl_chk #(.PERIOD(PERIOD), .MIX_POINT(MIX_POINT)) i_chk (
   .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cnt(cnt), .phase(phase),
   .blank_busy(blank_busy), .trip_s(trip_s),
   .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
   .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
);

// File: tb/test_chop_bridge_ctrl.sv
module test_chop_bridge_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_a = 1'b0;
   logic dir_b = 1'b0;
   logic blank_long = 1'b0;
   logic trip_async = 1'b0;
   logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   chop_bridge_ctrl i_chop_bridge_ctrl (
      .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
      .blank_long(blank_long), .trip_async(trip_async),
      .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
      .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
   );

   // dir, blank_long, trip count (31 = none), expected decay start, expected slow start (16 = none)
   typedef struct packed {
      logic [1:0] dir;
      logic       blong;
      logic [4:0] trip_c;
      logic [4:0] ds;
      logic [4:0] ss;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'b10, 1'b0, 5'd0,  5'd5,  5'd6 },
      '{2'b10, 1'b1, 5'd0,  5'd7,  5'd16},
      '{2'b01, 1'b0, 5'd3,  5'd5,  5'd6 },
      '{2'b01, 1'b0, 5'd5,  5'd6,  5'd16},
      '{2'b10, 1'b0, 5'd4,  5'd5,  5'd6 },
      '{2'b10, 1'b1, 5'd10, 5'd11, 5'd16},
      '{2'b01, 1'b1, 5'd31, 5'd16, 5'd16},
      '{2'b10, 1'b0, 5'd15, 5'd16, 5'd16},
      '{2'b10, 1'b0, 5'd14, 5'd15, 5'd16}
   };

   function automatic logic [3:0] exp_gates(logic [1:0] dir, int k, int ds, int ss);
      logic fwd = (dir == 2'b10);
      if (k < ds)       return fwd ? 4'b1001 : 4'b0110;
      else if (k >= ss) return 4'b0101;
      else              return fwd ? 4'b0110 : 4'b1001;
   endfunction

   task automatic check(string req, logic [3:0] exp);
      logic [3:0] got = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: gates %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic go_stop();
      @(negedge clk);
      dir_a = 1'b0; dir_b = 1'b0; trip_async = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 reset", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after reset", 4'b0000);

      // R8: stop ignores trip
      trip_async = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R8 stop", 4'b0000);
      end
      trip_async = 1'b0;

      // R8: brake
      dir_a = 1'b1; dir_b = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R8 brake", 4'b0101);
      end
      go_stop();

      // Vector walk: R1 R2 R3 R4 R5 R6, then R9 on the wrap
      for (int v = 0; v < NV; v++) begin
         vec_t tv = VECS[v];
         int tc = int'(tv.trip_c);
         dir_a = tv.dir[1]; dir_b = tv.dir[0]; blank_long = tv.blong;
         if (tc != 31 && tc < 2) trip_async = 1'b1;
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            check($sformatf("R1/R2/R3/R4/R5/R6 vec %0d cnt %0d", v, k),
                  exp_gates(tv.dir, k, int'(tv.ds), int'(tv.ss)));
            if (tc != 31 && tc >= 2 && k == tc - 2) trip_async = 1'b1;
         end
         @(negedge clk);
         check($sformatf("R9 vec %0d new period charge", v),
               exp_gates(tv.dir, 0, 16, 16));
         go_stop();
      end

      // R7: direction change mid-period restarts period and blanking
      blank_long = 1'b0;
      dir_a = 1'b1; dir_b = 1'b0; trip_async = 1'b1;
      for (int k = 0; k < 8; k++) @(negedge clk);
      check("R7 pre-change slow", 4'b0101);
      dir_a = 1'b0; dir_b = 1'b1;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         check($sformatf("R7 after change cnt %0d", k), exp_gates(2'b01, k, 5, 6));
      end
      go_stop();

      // R11: reset while driving
      dir_a = 1'b1; dir_b = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R11 reset while driving", 4'b0000);
      @(negedge clk);
      check("R11 reset held", 4'b0000);
      dir_a = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 stop after reset", 4'b0000);

      finish_run();
   end

endmodule